// File: doc/BRIEF.md
# Width-Matching Memory Port

This block puts a small 36-bit-wide storage array behind an external data bus that can be 36, 18 or 9 bits wide. Two static configuration pins pick the width. A fourth encoding of the same pins keeps every output lane released while the port is still enabled. In the narrow modes, two sub-word select inputs act as extra low-order address bits. They choose which half or which 9-bit lane of the stored word is moved.

A narrow write changes only the chosen lanes of the addressed word, using a per-lane write mask; the block never reads the word back to merge it. A narrow read moves the chosen half or lane down to the low bits of the output bus. Each 9-bit output lane has its own output enable, so the unused lanes can be put in high impedance at the pad. Reads are registered with one cycle of latency.

A change on the configuration pins is reported for one cycle. During that cycle the port neither writes nor drives.

Top module: `bus_match_port`

## Requirements
- R1: After reset, with both configuration pins low, `laneOe` is 0000, `dataOut` is all zeros and `configSettling` is 0.
- R2: With {busMatch,busSize}=00 (full width), a write stores all 36 bits of `dataIn`. A read returns the whole word on `dataOut` with `laneOe`=1111. `wordSel` and `byteSel` have no effect in this mode.
- R3: With {busMatch,busSize}=10 (half width), a read returns bits 35..18 of the word on `dataOut[17:0]` when `wordSel`=1, and bits 17..0 when `wordSel`=0. `dataOut[35:18]` is zero, `laneOe`=0011 and `byteSel` is ignored. Bit k of `laneOe` enables lane k, which is bits 9k..9k+8.
- R4: In half width, a write copies `dataIn[17:0]` into the half chosen by `wordSel` and leaves the other half unchanged.
- R5: With {busMatch,busSize}=11 (byte width), a read returns lane {wordSel,byteSel} of the word on `dataOut[8:0]`. The encodings are 00 for lane 0 and 11 for lane 3. The other bits of `dataOut` are zero and `laneOe`=0001.
- R6: In byte width, a write copies `dataIn[8:0]` into lane {wordSel,byteSel} only.
- R7: With {busMatch,busSize}=01 (I/O disabled), reads leave `laneOe`=0000 and `dataOut` zero, and writes change no stored bit.
- R8: Read data and lane enables appear on the cycle after the read strobe. A cycle without a read strobe gives `laneOe`=0000 and `dataOut`=0 on the next cycle.
- R9: `configSettling` is high in exactly the cycle in which the pins differ from their value in the previous cycle; the reference value after reset is 00. In that cycle a write is dropped, `laneOe` and `dataOut` are forced to zero, and a read issued then returns nothing.
- R10: When the read and write strobes are asserted together, the write is performed and the next cycle shows `laneOe`=0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busMatch | input | 1 | Width configuration pin, high for the narrow modes |
| busSize | input | 1 | Width configuration pin, picks the byte or half width, or the disabled mode |
| addr | input | ADDR_W | Word address |
| wordSel | input | 1 | Half select, and the upper select bit of the lane |
| byteSel | input | 1 | Lower select bit of the lane in byte width |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| dataIn | input | 4*LANE_W | Write data, aligned to the low bits in the narrow modes |
| dataOut | output | 4*LANE_W | Registered read data, zero in the lanes that are not driven |
| laneOe | output | 4 | Output enable for each lane |
| configSettling | output | 1 | High in the cycle the configuration pins change |

## Verification
Read data and lane enables are due one clock edge after the strobe. The bench therefore drives every input on a falling edge, lets one rising edge pass and samples on the next falling edge. `configSettling` and the output gating it causes are combinational on the pins, so they are sampled 1 ns after the pins move, before any rising edge. The effect of a write is checked through a later read, and a read done after switching back to full width confirms that the neighbouring lanes were not touched.

// File: rtl/bmp_pkg.sv
package bmp_pkg;
  localparam int NUM_LANES = 4;

  // encoding is {busMatch, busSize}
  typedef enum logic [1:0] {
    MODE_FULL = 2'b00,
    MODE_OFF  = 2'b01,
    MODE_HALF = 2'b10,
    MODE_BYTE = 2'b11
  } busMode_e;

  typedef struct packed {
    busMode_e               mode;
    logic [1:0]             laneSel;
    logic [NUM_LANES-1:0]   wrMask;
    logic                   rdGo;
    logic                   quiet;
  } bmpCtrl_t;
endpackage

// File: rtl/bmp_ctrl.sv
module bmp_ctrl
  import bmp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     busMatch,
  input  logic     busSize,
  input  logic     wordSel,
  input  logic     byteSel,
  input  logic     rdEn,
  input  logic     wrEn,
  output bmpCtrl_t ctrl,
  output logic     configSettling
);
  logic [1:0] cfgQ;
  logic [1:0] cfgNow;
  busMode_e   mode;
  logic [NUM_LANES-1:0] laneMask;

  assign cfgNow = {busMatch, busSize};
  assign mode   = busMode_e'(cfgNow);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfgQ <= 2'b00;
    else        cfgQ <= cfgNow;
  end

  assign configSettling = (cfgNow != cfgQ);

  always_comb begin
    unique case (mode)
      MODE_FULL: laneMask = '1;
      MODE_HALF: laneMask = wordSel ? 4'b1100 : 4'b0011;
      MODE_BYTE: laneMask = 4'b0001 << {wordSel, byteSel};
      default:   laneMask = '0;
    endcase
  end

  always_comb begin
    ctrl.mode    = mode;
    ctrl.laneSel = {wordSel, byteSel};
    ctrl.wrMask  = (wrEn && !configSettling) ? laneMask : '0;
    ctrl.rdGo    = rdEn && !wrEn && !configSettling && (mode != MODE_OFF);
    ctrl.quiet   = configSettling;
  end
endmodule

// File: rtl/bmp_datapath.sv
module bmp_datapath
  import bmp_pkg::*;
#(
  parameter int LANE_W = 9,
  parameter int ADDR_W = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  bmpCtrl_t                       ctrl,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [LANE_W*NUM_LANES-1:0]    dataIn,
  output logic [LANE_W*NUM_LANES-1:0]    dataOut,
  output logic [NUM_LANES-1:0]           laneOe
);
  localparam int DATA_W = LANE_W * NUM_LANES;
  localparam int HALF_W = 2 * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0]    wrData;
  logic [DATA_W-1:0]    rdWord;
  logic [DATA_W-1:0]    rdSteer;
  logic [NUM_LANES-1:0] rdOe;
  logic [DATA_W-1:0]    doutQ;
  logic [NUM_LANES-1:0] oeQ;

  // narrow write data is replicated so every lane sees its source bits
  always_comb begin
    unique case (ctrl.mode)
      MODE_FULL: wrData = dataIn;
      MODE_HALF: wrData = {2{dataIn[HALF_W-1:0]}};
      default:   wrData = {NUM_LANES{dataIn[LANE_W-1:0]}};
    endcase
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (ctrl.wrMask[g]) laneMem[addr] <= wrData[g*LANE_W +: LANE_W];
    end
    assign rdWord[g*LANE_W +: LANE_W] = laneMem[addr];
  end

  always_comb begin
    rdSteer = '0;
    rdOe    = '0;
    unique case (ctrl.mode)
      MODE_FULL: begin
        rdSteer = rdWord;
        rdOe    = '1;
      end
      MODE_HALF: begin
        rdSteer[HALF_W-1:0] = ctrl.laneSel[1] ? rdWord[DATA_W-1:HALF_W] : rdWord[HALF_W-1:0];
        rdOe    = 4'b0011;
      end
      MODE_BYTE: begin
        rdSteer[LANE_W-1:0] = rdWord[int'(ctrl.laneSel)*LANE_W +: LANE_W];
        rdOe    = 4'b0001;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      doutQ <= '0;
      oeQ   <= '0;
    end else if (ctrl.rdGo) begin
      doutQ <= rdSteer;
      oeQ   <= rdOe;
    end else begin
      doutQ <= '0;
      oeQ   <= '0;
    end
  end

  assign dataOut = ctrl.quiet ? '0 : doutQ;
  assign laneOe  = ctrl.quiet ? '0 : oeQ;
endmodule

// File: rtl/bus_match_port.sv
module bus_match_port
  import bmp_pkg::*;
#(
  parameter  int LANE_W = 9,
  parameter  int ADDR_W = 4,
  localparam int DATA_W = LANE_W * NUM_LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busMatch,
  input  logic              busSize,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wordSel,
  input  logic              byteSel,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic [NUM_LANES-1:0] laneOe,
  output logic              configSettling
);
  bmpCtrl_t ctrl;

  bmp_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .busMatch(busMatch), .busSize(busSize),
    .wordSel(wordSel), .byteSel(byteSel), .rdEn(rdEn), .wrEn(wrEn),
    .ctrl(ctrl), .configSettling(configSettling)
  );

  bmp_datapath #(.LANE_W(LANE_W), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut), .laneOe(laneOe)
  );
endmodule

// File: rtl/bus_match_port_chk.sv
module bus_match_port_chk #(
  parameter int LANE_W = 9
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busMatch,
  input logic                  busSize,
  input logic                  rdEn,
  input logic                  wrEn,
  input logic                  configSettling,
  input logic [3:0]            laneOe,
  input logic [4*LANE_W-1:0]   dataOut
);
  AST_SETTLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    configSettling |-> (laneOe == 4'b0000 && dataOut == '0)); // R9

  AST_OFF_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(busMatch) && $past(busSize)) |-> laneOe == 4'b0000); // R7

  AST_NO_READ_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rdEn) |-> laneOe == 4'b0000); // R8

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wrEn) |-> laneOe == 4'b0000); // R10

  AST_HALF_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busMatch && !busSize && rdEn && !wrEn && !configSettling) && !configSettling)
      |-> laneOe == 4'b0011); // R3

  AST_BYTE_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busMatch && busSize && rdEn && !wrEn && !configSettling) && !configSettling)
      |-> laneOe == 4'b0001); // R5

  for (genvar k = 0; k < 4; k++) begin : gIdle
    AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !laneOe[k] |-> dataOut[k*LANE_W +: LANE_W] == '0); // R3
  end
endmodule

bind bus_match_port bus_match_port_chk #(.LANE_W(LANE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busMatch(busMatch), .busSize(busSize),
  .rdEn(rdEn), .wrEn(wrEn), .configSettling(configSettling),
  .laneOe(laneOe), .dataOut(dataOut)
);

// File: tb/bus_match_port_tb_top.sv
`timescale 1ns/1ps
module bus_match_port_tb_top;
  localparam int LW = 9;
  localparam int AW = 4;
  localparam int DW = 4 * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bm = 1'b0, sz = 1'b0, wa = 1'b0, ba = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic [3:0]    oe;
  logic          settle;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] model [DEPTH];

  always #2.5 clk = ~clk;

  bus_match_port #(.LANE_W(LW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .busMatch(bm), .busSize(sz), .addr(addr),
    .wordSel(wa), .byteSel(ba), .rdEn(rd), .wrEn(wr), .dataIn(din),
    .dataOut(dout), .laneOe(oe), .configSettling(settle)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] wrMaskOf(logic b, logic s, logic w, logic y);
    case ({b, s})
      2'b00:   return 4'b1111;
      2'b10:   return w ? 4'b1100 : 4'b0011;
      2'b11:   return 4'b0001 << {w, y};
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [DW-1:0] pat(int a, int salt);
    logic [DW-1:0] v;
    v = DW'(a * 36'h2468ACE1 + salt * 36'h13579BDF) ^ 36'h95A5A5A5A;
    return v;
  endfunction

  task automatic doWrite(input int a, input logic w, input logic y, input logic [DW-1:0] d);
    logic [3:0] m;
    addr = AW'(a); wa = w; ba = y; din = d; wr = 1'b1;
    m = wrMaskOf(bm, sz, w, y);
    for (int k = 0; k < 4; k++) begin
      if (m[k]) begin
        if (!bm)     model[a][k*LW +: LW] = d[k*LW +: LW];
        else if (sz) model[a][k*LW +: LW] = d[LW-1:0];
        else         model[a][k*LW +: LW] = d[(k%2)*LW +: LW];
      end
    end
    step();
    wr = 1'b0;
  endtask

  task automatic doRead(input int a, input logic w, input logic y, input string tag);
    logic [DW-1:0] expD;
    logic [3:0]    expOe;
    addr = AW'(a); wa = w; ba = y; rd = 1'b1;
    step();
    rd = 1'b0;
    expD = '0;
    case ({bm, sz})
      2'b00: begin expD = model[a]; expOe = 4'b1111; end
      2'b10: begin expD[2*LW-1:0] = w ? model[a][DW-1:2*LW] : model[a][2*LW-1:0]; expOe = 4'b0011; end
      2'b11: begin expD[LW-1:0] = model[a][{w, y}*LW +: LW]; expOe = 4'b0001; end
      default: expOe = 4'b0000;
    endcase
    check({tag, " oe"}, 64'(oe), 64'(expOe));
    check({tag, " data"}, 64'(dout), 64'(expD));
  endtask

  task automatic setCfg(input logic b, input logic s);
    bm = b; sz = s;
    #1;
    check("R9 settling raised", 64'(settle), 64'd1);
    @(negedge clk);
    check("R9 settling one cycle", 64'(settle), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check("R1 oe", 64'(oe), 64'd0);
    check("R1 data", 64'(dout), 64'd0);
    check("R1 settling", 64'(settle), 64'd0);

    // R2 full width: all addresses, all sub-word selects
    for (int a = 0; a < DEPTH; a++) doWrite(a, a[0], a[1], pat(a, 1));
    for (int a = 0; a < DEPTH; a++)
      for (int s = 0; s < 4; s++) doRead(a, s[1], s[0], "R2 full read");

    // R8 idle cycle after a read
    doRead(3, 1'b0, 1'b0, "R8 read");
    step();
    check("R8 idle oe", 64'(oe), 64'd0);
    check("R8 idle data", 64'(dout), 64'd0);

    // R3 / R4 half width
    setCfg(1'b1, 1'b0);
    for (int a = 0; a < DEPTH; a++) doWrite(a, a[0], ~a[1], pat(a, 2));
    for (int a = 0; a < DEPTH; a++)
      for (int s = 0; s < 4; s++) doRead(a, s[1], s[0], "R3 half read");
    setCfg(1'b0, 1'b0);
    for (int a = 0; a < DEPTH; a++) doRead(a, 1'b0, 1'b0, "R4 half merge");

    // R5 / R6 byte width
    setCfg(1'b1, 1'b1);
    for (int a = 0; a < DEPTH; a++)
      for (int l = 0; l < 4; l++)
        if ((a + l) % 3 == 0) doWrite(a, l[1], l[0], pat(a * 4 + l, 3));
    for (int a = 0; a < DEPTH; a++)
      for (int l = 0; l < 4; l++) doRead(a, l[1], l[0], "R5 byte read");
    setCfg(1'b0, 1'b0);
    for (int a = 0; a < DEPTH; a++) doRead(a, 1'b1, 1'b1, "R6 byte merge");

    // R7 disabled mode
    setCfg(1'b0, 1'b1);
    for (int a = 0; a < DEPTH; a += 3) doWrite(a, a[0], a[1], ~pat(a, 4));
    for (int a = 0; a < DEPTH; a += 2) doRead(a, a[1], a[0], "R7 off read");
    setCfg(1'b0, 1'b0);
    for (int a = 0; a < DEPTH; a++) doRead(a, 1'b0, 1'b1, "R7 off no write");

    // R10 read and write together
    addr = AW'(5); din = pat(77, 5); rd = 1'b1; wr = 1'b1;
    model[5] = din;
    step();
    rd = 1'b0; wr = 1'b0;
    check("R10 no read data oe", 64'(oe), 64'd0);
    doRead(5, 1'b0, 1'b0, "R10 write done");

    // R9 write during settling is dropped
    bm = 1'b1; sz = 1'b0; wr = 1'b1; addr = AW'(2); wa = 1'b0; din = pat(99, 6);
    #1;
    check("R9 settle with write", 64'(settle), 64'd1);
    @(negedge clk);
    wr = 1'b0;
    check("R9 settle cleared", 64'(settle), 64'd0);
    doRead(2, 1'b0, 1'b0, "R9 dropped write");

    // R9 read during settling returns nothing
    bm = 1'b0; sz = 1'b0; rd = 1'b1; addr = AW'(2);
    step();
    rd = 1'b0;
    check("R9 settle read oe", 64'(oe), 64'd0);
    check("R9 settle read data", 64'(dout), 64'd0);

    // R9 outputs forced off while settling
    doRead(6, 1'b0, 1'b0, "R9 pre-read");
    bm = 1'b1; sz = 1'b1;
    #1;
    check("R9 gated oe", 64'(oe), 64'd0);
    check("R9 gated data", 64'(dout), 64'd0);
    @(negedge clk);
    doRead(6, 1'b1, 1'b0, "R5 after settle");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule